// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block holds a small set of recent translations from virtual page number to physical frame number. A lookup presents a full virtual address. Every stored tag is compared against the page-number field in parallel. One clock later the block reports whether the page was found, the physical address, and the entry's write permission. The physical address is the stored frame number with the untranslated page offset of the request placed below it. With the default parameters the addresses are 32 bits wide and the pages are 4 KB, so the offset is 12 bits and the page number is 20 bits.

When a lookup misses, the page-table walk runs outside this block and then installs the translation through the fill port. The fill goes to an entry in this order of preference: the entry that already holds the same page, then the lowest-numbered free entry, then the least recently used entry. Software-visible maintenance has two inputs. A single-page invalidate is used when a page's protection changes. A full flush is used on a context switch.

Top module: `tlb_xlat`

## Requirements
- R1: After reset no entry is valid, and `lkp_done_o`, `lkp_hit_o`, `lkp_wr_o` and `lkp_pa_o` are all zero. A lookup made right after reset misses.
- R2: `lkp_done_o` is high in exactly the cycle after the cycle in which `lkp_req_i` was high, and in no other cycle.
- R3: On a hit, `lkp_pa_o` is the stored frame number in bits [PA_W-1:OFS_W] and bits [OFS_W-1:0] of the request address in bits [OFS_W-1:0]. `lkp_wr_o` returns the stored permission bit, where 1 means writable and 0 means read-only.
- R4: On a miss, `lkp_hit_o`, `lkp_wr_o` and `lkp_pa_o` are all zero.
- R5: A fill in one cycle is visible to a lookup in the next cycle.
- R6: A fill whose page is already stored overwrites that entry in place. The buffer never holds two valid entries with the same page number.
- R7: A fill takes a free entry before it evicts a valid one.
- R8: A fill into a full buffer replaces the entry that was used least recently. A fill counts as a use, and so does a lookup hit.
- R9: A lookup hit makes its entry the most recently used. If a fill is accepted in the same cycle, the fill's entry is the one promoted.
- R10: A single-page invalidate clears only the entry that matches its page number.
- R11: A flush clears every entry.
- R12: When a fill and an invalidate name the same page in the same cycle, the invalidate wins. No entry for that page remains, and no entry is evicted.
- R13: A lookup made in the same cycle as a flush reports a miss, and a fill in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_req_i | input | 1 | Lookup request |
| lkp_va_i | input | VA_W | Virtual address to translate |
| lkp_done_o | output | 1 | Lookup result valid |
| lkp_hit_o | output | 1 | Translation found |
| lkp_pa_o | output | PA_W | Physical address, zero on a miss |
| lkp_wr_o | output | 1 | Entry writable, zero on a miss |
| fill_req_i | input | 1 | Install a translation |
| fill_vpn_i | input | VA_W-OFS_W | Page number to install |
| fill_pfn_i | input | PA_W-OFS_W | Frame number to install |
| fill_wr_i | input | 1 | Permission bit to install |
| inv_req_i | input | 1 | Invalidate one page |
| inv_vpn_i | input | VA_W-OFS_W | Page number to invalidate |
| flush_i | input | 1 | Invalidate all entries |

## Verification
Each lookup result is due exactly one cycle after its request. Fills, invalidates and flushes take effect at the same edge, so a lookup in the following cycle sees them. The bench's driver places each expectation in a queue together with its due cycle, which is the cycle of the request plus one. The monitor samples at the falling edge. It compares the head of the queue only in that due cycle, and it flags any `lkp_done_o` seen in a cycle when nothing is due. The expected replacement victims follow a hand-worked order of recent use that runs through the whole sequence.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int unsigned TLB_VA_W    = 32;
  parameter int unsigned TLB_PA_W    = 32;
  parameter int unsigned TLB_OFS_W   = 12;
  parameter int unsigned TLB_ENTRIES = 8;

  // index of the lowest set bit of a vector up to 64 wide
  function automatic int unsigned lowest_set(input logic [63:0] vec);
    int unsigned idx;
    idx = 0;
    for (int i = 63; i >= 0; i--) begin
      if (vec[i]) idx = i;
    end
    return idx;
  endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int unsigned N     = 8,
  parameter int unsigned TAG_W = 20
) (
  input  logic [N-1:0]            valid_i,
  input  logic [N-1:0][TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0]        key_i,
  output logic [N-1:0]            match_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (tag_i[g] == key_i);
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int unsigned N = 8,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          touch_i,
  input  logic [IW-1:0] touch_idx_i,
  output logic [IW-1:0] victim_o
);
  // age 0 = most recent, N-1 = least recent; ages stay a permutation
  logic [N-1:0][IW-1:0] age_q;
  logic [IW-1:0]        ref_age;

  assign ref_age = age_q[touch_idx_i];

  for (genvar g = 0; g < N; g++) begin : g_age
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        age_q[g] <= IW'(g);
      end else if (touch_i) begin
        if (touch_idx_i == IW'(g))   age_q[g] <= '0;
        else if (age_q[g] < ref_age) age_q[g] <= age_q[g] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_o = '0;
    for (int i = 0; i < N; i++) begin
      if (age_q[i] == IW'(N - 1)) victim_o = IW'(i);
    end
  end
endmodule

// File: rtl/tlb_alloc.sv
module tlb_alloc
  import tlb_pkg::*;
#(
  parameter int unsigned N = 8,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  valid_i,
  input  logic [N-1:0]  same_i,
  input  logic [IW-1:0] victim_i,
  output logic [IW-1:0] slot_o
);
  logic [63:0] free_vec;
  logic [63:0] same_vec;

  always_comb begin
    free_vec = '0;
    same_vec = '0;
    free_vec[N-1:0] = ~valid_i;
    same_vec[N-1:0] = same_i;
    // priority: same page, then lowest free, then LRU victim
    if (|same_i)        slot_o = IW'(lowest_set(same_vec));
    else if (&valid_i)  slot_o = victim_i;
    else                slot_o = IW'(lowest_set(free_vec));
  end
endmodule

// File: rtl/tlb_xlat.sv
module tlb_xlat
  import tlb_pkg::*;
#(
  parameter int unsigned VA_W  = TLB_VA_W,
  parameter int unsigned PA_W  = TLB_PA_W,
  parameter int unsigned OFS_W = TLB_OFS_W,
  parameter int unsigned N     = TLB_ENTRIES,
  localparam int unsigned VPN_W = VA_W - OFS_W,
  localparam int unsigned PFN_W = PA_W - OFS_W,
  localparam int unsigned IW    = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lkp_req_i,
  input  logic [VA_W-1:0]  lkp_va_i,
  output logic             lkp_done_o,
  output logic             lkp_hit_o,
  output logic [PA_W-1:0]  lkp_pa_o,
  output logic             lkp_wr_o,
  input  logic             fill_req_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PFN_W-1:0] fill_pfn_i,
  input  logic             fill_wr_i,
  input  logic             inv_req_i,
  input  logic [VPN_W-1:0] inv_vpn_i,
  input  logic             flush_i
);
  logic [N-1:0]            valid_q;
  logic [N-1:0][VPN_W-1:0] tag_q;
  logic [N-1:0][PFN_W-1:0] pfn_q;
  logic [N-1:0]            perm_q;

  logic [VPN_W-1:0] lkp_vpn;
  logic [OFS_W-1:0] lkp_ofs;
  logic [N-1:0]     lk_match, fill_match, inv_match;
  logic [PFN_W-1:0] lk_pfn;
  logic             lk_perm;
  logic [IW-1:0]    lk_idx;
  logic             lk_hit;
  logic             fill_we;
  logic [IW-1:0]    fill_slot;
  logic [IW-1:0]    victim;
  logic             touch;
  logic [IW-1:0]    touch_idx;

  assign lkp_vpn = lkp_va_i[VA_W-1:OFS_W];
  assign lkp_ofs = lkp_va_i[OFS_W-1:0];

  tlb_cam #(.N(N), .TAG_W(VPN_W)) u_cam_lkp (
    .valid_i(valid_q), .tag_i(tag_q), .key_i(lkp_vpn), .match_o(lk_match)
  );
  tlb_cam #(.N(N), .TAG_W(VPN_W)) u_cam_fill (
    .valid_i(valid_q), .tag_i(tag_q), .key_i(fill_vpn_i), .match_o(fill_match)
  );
  tlb_cam #(.N(N), .TAG_W(VPN_W)) u_cam_inv (
    .valid_i(valid_q), .tag_i(tag_q), .key_i(inv_vpn_i), .match_o(inv_match)
  );

  // at most one match: OR-select is safe
  always_comb begin
    lk_pfn  = '0;
    lk_perm = 1'b0;
    lk_idx  = '0;
    for (int i = 0; i < N; i++) begin
      if (lk_match[i]) begin
        lk_pfn  = lk_pfn | pfn_q[i];
        lk_perm = lk_perm | perm_q[i];
        lk_idx  = lk_idx | IW'(i);
      end
    end
  end

  assign lk_hit  = lkp_req_i && (|lk_match) && !flush_i;
  assign fill_we = fill_req_i && !flush_i &&
                   !(inv_req_i && (inv_vpn_i == fill_vpn_i));

  tlb_alloc #(.N(N)) u_alloc (
    .valid_i (valid_q),
    .same_i  (fill_match),
    .victim_i(victim),
    .slot_o  (fill_slot)
  );

  assign touch     = fill_we || lk_hit;
  assign touch_idx = fill_we ? fill_slot : lk_idx;

  tlb_lru #(.N(N)) u_lru (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .touch_i    (touch),
    .touch_idx_i(touch_idx),
    .victim_o   (victim)
  );

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic wr_sel;
    assign wr_sel = fill_we && (fill_slot == IW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             valid_q[g] <= 1'b0;
      else if (flush_i)        valid_q[g] <= 1'b0;
      else if (wr_sel)         valid_q[g] <= 1'b1;
      else if (inv_match[g] && inv_req_i) valid_q[g] <= 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q[g]  <= '0;
        pfn_q[g]  <= '0;
        perm_q[g] <= 1'b0;
      end else if (wr_sel) begin
        tag_q[g]  <= fill_vpn_i;
        pfn_q[g]  <= fill_pfn_i;
        perm_q[g] <= fill_wr_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lkp_done_o <= 1'b0;
      lkp_hit_o  <= 1'b0;
      lkp_pa_o   <= '0;
      lkp_wr_o   <= 1'b0;
    end else begin
      lkp_done_o <= lkp_req_i;
      lkp_hit_o  <= lk_hit;
      lkp_pa_o   <= lk_hit ? {lk_pfn, lkp_ofs} : '0;
      lkp_wr_o   <= lk_hit && lk_perm;
    end
  end
endmodule

// File: rtl/tlb_xlat_chk.sv
module tlb_xlat_chk #(
  parameter int unsigned N     = 8,
  parameter int unsigned VPN_W = 20,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFS_W = 12
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  lkp_req_i,
  input logic [OFS_W-1:0]      lkp_ofs_i,
  input logic                  lkp_done_o,
  input logic                  lkp_hit_o,
  input logic [PA_W-1:0]       lkp_pa_o,
  input logic                  lkp_wr_o,
  input logic                  fill_req_i,
  input logic [VPN_W-1:0]      fill_vpn_i,
  input logic                  inv_req_i,
  input logic [VPN_W-1:0]      inv_vpn_i,
  input logic                  flush_i,
  input logic [N-1:0]          valid_q,
  input logic [N-1:0][VPN_W-1:0] tag_q
);
  logic             dup;
  logic [VPN_W-1:0] last_fill_vpn_q;
  logic             last_present;

  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        if (valid_q[i] && valid_q[j] && tag_q[i] == tag_q[j]) dup = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_fill_vpn_q <= '0;
    else         last_fill_vpn_q <= fill_vpn_i;
  end

  always_comb begin
    last_present = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (valid_q[i] && tag_q[i] == last_fill_vpn_q) last_present = 1'b1;
    end
  end

  p_done_due_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_req_i |=> lkp_done_o);
  p_done_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_req_i |=> !lkp_done_o);
  p_hit_has_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_hit_o |-> lkp_done_o);
  p_offset_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_done_o && lkp_hit_o) |-> lkp_pa_o[OFS_W-1:0] == $past(lkp_ofs_i));
  p_miss_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_done_o && !lkp_hit_o) |-> (lkp_pa_o == '0 && !lkp_wr_o));
  p_no_dup_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dup);
  p_flush_empty_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> valid_q == '0);
  p_inv_beats_fill_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_i && inv_req_i && inv_vpn_i == fill_vpn_i) |=> !last_present);
  p_flush_miss_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_req_i && flush_i) |=> !lkp_hit_o);
endmodule

bind tlb_xlat tlb_xlat_chk #(
  .N(N), .VPN_W(VPN_W), .PA_W(PA_W), .OFS_W(OFS_W)
) i_tlb_xlat_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .lkp_req_i (lkp_req_i),
  .lkp_ofs_i (lkp_va_i[OFS_W-1:0]),
  .lkp_done_o(lkp_done_o),
  .lkp_hit_o (lkp_hit_o),
  .lkp_pa_o  (lkp_pa_o),
  .lkp_wr_o  (lkp_wr_o),
  .fill_req_i(fill_req_i),
  .fill_vpn_i(fill_vpn_i),
  .inv_req_i (inv_req_i),
  .inv_vpn_i (inv_vpn_i),
  .flush_i   (flush_i),
  .valid_q   (valid_q),
  .tag_q     (tag_q)
);

// File: tb/test_tlb_xlat.sv
module test_tlb_xlat;
  localparam time CLK_P = 10ns;
  localparam int  WD_CYC = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lkp_req_i = 1'b0;
  logic [31:0] lkp_va_i = '0;
  logic        lkp_done_o, lkp_hit_o, lkp_wr_o;
  logic [31:0] lkp_pa_o;
  logic        fill_req_i = 1'b0;
  logic [19:0] fill_vpn_i = '0;
  logic [19:0] fill_pfn_i = '0;
  logic        fill_wr_i = 1'b0;
  logic        inv_req_i = 1'b0;
  logic [19:0] inv_vpn_i = '0;
  logic        flush_i = 1'b0;

  always #(CLK_P / 2) clk_i = ~clk_i;

  tlb_xlat i_tlb_xlat (
    .clk_i, .rst_ni, .lkp_req_i, .lkp_va_i, .lkp_done_o, .lkp_hit_o,
    .lkp_pa_o, .lkp_wr_o, .fill_req_i, .fill_vpn_i, .fill_pfn_i, .fill_wr_i,
    .inv_req_i, .inv_vpn_i, .flush_i
  );

  typedef struct {
    int          due;
    bit          hit;
    logic [31:0] pa;
    bit          wr;
    string       rq;
  } exp_t;

  exp_t exp_q[$];
  exp_t mon_e;
  int   cyc = 0;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   ended = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // monitor: compare only in the due cycle, flag any stray done
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
        mon_e = exp_q.pop_front();
        n_vec++;
        if (!(lkp_done_o && lkp_hit_o == mon_e.hit && lkp_pa_o == mon_e.pa &&
              lkp_wr_o == mon_e.wr)) begin
          n_bad++;
          $display("FAIL %s: done=%0b hit=%0b pa=%h wr=%0b, expected done=1 hit=%0b pa=%h wr=%0b",
                   mon_e.rq, lkp_done_o, lkp_hit_o, lkp_pa_o, lkp_wr_o,
                   mon_e.hit, mon_e.pa, mon_e.wr);
        end
      end else if (lkp_done_o) begin
        n_vec++;
        n_bad++;
        $display("FAIL R2: done=1 at cycle %0d, expected done=0", cyc);
      end
    end
  end

  function automatic logic [19:0] vp(input int k);
    return 20'h00010 + 20'(k);
  endfunction
  function automatic logic [19:0] fp(input int k);
    return 20'hA0000 + 20'(k);
  endfunction
  function automatic bit pw(input int k);
    return k[0];
  endfunction

  task automatic step(input bit lk, input logic [31:0] va, input bit eh,
                      input logic [31:0] epa, input bit ew, input string rq,
                      input bit fl, input logic [19:0] fv, input logic [19:0] fpn,
                      input bit fw, input bit iv, input logic [19:0] ivv,
                      input bit fsh);
    exp_t e;
    lkp_req_i  = lk;  lkp_va_i  = va;
    fill_req_i = fl;  fill_vpn_i = fv; fill_pfn_i = fpn; fill_wr_i = fw;
    inv_req_i  = iv;  inv_vpn_i  = ivv;
    flush_i    = fsh;
    if (lk) begin
      e.due = cyc + 1; e.hit = eh; e.pa = epa; e.wr = ew; e.rq = rq;
      exp_q.push_back(e);
    end
    @(negedge clk_i);
    lkp_req_i = 1'b0; fill_req_i = 1'b0; inv_req_i = 1'b0; flush_i = 1'b0;
  endtask

  task automatic lk_hit(input logic [19:0] v, input logic [11:0] o,
                        input logic [19:0] p, input bit w, input string rq);
    step(1'b1, {v, o}, 1'b1, {p, o}, w, rq, 1'b0, '0, '0, 1'b0, 1'b0, '0, 1'b0);
  endtask
  task automatic lk_miss(input logic [19:0] v, input logic [11:0] o, input string rq);
    step(1'b1, {v, o}, 1'b0, '0, 1'b0, rq, 1'b0, '0, '0, 1'b0, 1'b0, '0, 1'b0);
  endtask
  task automatic fill(input logic [19:0] v, input logic [19:0] p, input bit w);
    step(1'b0, '0, 1'b0, '0, 1'b0, "", 1'b1, v, p, w, 1'b0, '0, 1'b0);
  endtask
  task automatic inval(input logic [19:0] v);
    step(1'b0, '0, 1'b0, '0, 1'b0, "", 1'b0, '0, '0, 1'b0, 1'b1, v, 1'b0);
  endtask
  task automatic idle();
    step(1'b0, '0, 1'b0, '0, 1'b0, "", 1'b0, '0, '0, 1'b0, 1'b0, '0, 1'b0);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk_i);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: run still active after %0d cycles, expected completion", WD_CYC);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    n_vec++;
    if (lkp_done_o || lkp_hit_o || lkp_wr_o || lkp_pa_o != '0) begin
      n_bad++;
      $display("FAIL R1: done=%0b hit=%0b wr=%0b pa=%h, expected all zero",
               lkp_done_o, lkp_hit_o, lkp_wr_o, lkp_pa_o);
    end
    lk_miss(vp(0), 12'h123, "R1 lookup after reset");
    idle();

    // R7 fill eight distinct pages into free entries, R5 R3 read back
    for (int k = 0; k < 8; k++) fill(vp(k), fp(k), pw(k));
    for (int k = 0; k < 8; k++) lk_hit(vp(k), 12'(k * 300), fp(k), pw(k), "R5 R3 R7 fill then hit");
    idle();
    // R9 refresh page 0; LRU is now page 1
    lk_hit(vp(0), 12'hFFF, fp(0), pw(0), "R9 refresh");
    // R8 full: evicts page 1
    fill(20'h00040, 20'hB0040, 1'b1);
    lk_miss(vp(1), 12'h000, "R8 LRU victim evicted");
    lk_hit(20'h00040, 12'h5A3, 20'hB0040, 1'b1, "R8 new entry");
    lk_hit(vp(0), 12'h001, fp(0), pw(0), "R9 refreshed entry kept");
    lk_hit(vp(2), 12'h002, fp(2), pw(2), "R8 non-victim kept");
    // order now 3,4,5,6,7,40,0,2: next victim page 3
    fill(20'h00041, 20'hB0041, 1'b0);
    lk_miss(vp(3), 12'h010, "R8 second victim");
    lk_hit(vp(4), 12'h020, fp(4), pw(4), "R8 next oldest kept");
    // R6 refill existing page 5 in place
    fill(vp(5), 20'hC0005, 1'b1);
    lk_hit(vp(0), 12'h100, fp(0), pw(0), "R6 no duplicate slot");
    lk_hit(vp(2), 12'h100, fp(2), pw(2), "R6 no duplicate slot");
    lk_hit(vp(4), 12'h100, fp(4), pw(4), "R6 no duplicate slot");
    lk_hit(vp(5), 12'h7FF, 20'hC0005, 1'b1, "R6 overwritten in place");
    lk_hit(vp(6), 12'h100, fp(6), pw(6), "R6 no duplicate slot");
    lk_hit(vp(7), 12'h100, fp(7), pw(7), "R6 no duplicate slot");
    lk_hit(20'h00040, 12'h100, 20'hB0040, 1'b1, "R6 no duplicate slot");
    lk_hit(20'h00041, 12'h100, 20'hB0041, 1'b0, "R6 no duplicate slot");
    // R10 single-page invalidate
    inval(vp(6));
    lk_miss(vp(6), 12'h0AB, "R10 invalidated page");
    lk_hit(vp(7), 12'h0AB, fp(7), pw(7), "R10 neighbour untouched");
    // R7 free slot used before LRU (page 0 is LRU)
    fill(20'h00050, 20'hB0050, 1'b0);
    lk_hit(vp(0), 12'h200, fp(0), pw(0), "R7 LRU not evicted while free slot");
    lk_hit(vp(2), 12'h200, fp(2), pw(2), "R7 kept");
    lk_hit(vp(4), 12'h200, fp(4), pw(4), "R7 kept");
    lk_hit(vp(5), 12'h200, 20'hC0005, 1'b1, "R7 kept");
    lk_hit(vp(7), 12'h200, fp(7), pw(7), "R7 kept");
    lk_hit(20'h00040, 12'h200, 20'hB0040, 1'b1, "R7 kept");
    lk_hit(20'h00041, 12'h200, 20'hB0041, 1'b0, "R7 kept");
    lk_hit(20'h00050, 12'h200, 20'hB0050, 1'b0, "R7 filled free slot");
    // R12 fill and invalidate same page; page 0 is LRU and must survive
    step(1'b0, '0, 1'b0, '0, 1'b0, "", 1'b1, 20'h00060, 20'hB0060, 1'b1,
         1'b1, 20'h00060, 1'b0);
    lk_miss(20'h00060, 12'h300, "R12 invalidate wins");
    lk_hit(vp(0), 12'h300, fp(0), pw(0), "R12 no eviction");
    // R13 lookup with flush
    step(1'b1, {vp(2), 12'h400}, 1'b0, '0, 1'b0, "R13 lookup during flush",
         1'b0, '0, '0, 1'b0, 1'b0, '0, 1'b1);
    lk_miss(vp(0), 12'h400, "R11 flushed");
    lk_miss(20'h00050, 12'h400, "R11 flushed");
    idle();
    fill(20'h00070, 20'hD0070, 1'b1);
    lk_hit(20'h00070, 12'hFFF, 20'hD0070, 1'b1, "R5 fill after flush");
    repeat (3) idle();
    if (exp_q.size() != 0) begin
      n_vec++;
      n_bad++;
      $display("FAIL R2: %0d results never arrived, expected 0 pending", exp_q.size());
    end
    finish_run();
  end
endmodule